// File: doc/BRIEF.md
# Standby bus wake-up filter

This block watches a digitised bus line while a transceiver rests in its low-power state. Each clock cycle it samples one bit that says whether the bus is dominant or recessive. It drives an active-low request output that tells the host bus activity has been seen. The output is not a latch. It follows the bus in both directions, but a change of bus state reaches the output only after the new state has held for a programmable number of clock cycles. Spikes and short gaps are therefore rejected in both directions.

A second and much longer timer runs while the bus is dominant. It protects against a bus that is clamped dominant by a short circuit or a faulty node. When this timer expires, the request is withdrawn. It stays withdrawn until the filtered bus has gone back to recessive, so a stuck bus cannot keep the host awake. A separate registered mode output follows only the mode-select input. A wake request never changes the mode by itself; the host must drive the select input to normal.

Both lengths are parameters given in clock cycles. The timeout length is expected to be larger than the filter length. At 8 MHz, the defaults give a 1.5 µs filter and a 2 ms timeout.

Top module: `stby_wake_mon`

## Requirements
- R1: During reset and after reset with standby selected, `wake_n` is 1 and `mode_normal` is 0.
- R2: A dominant level (`bus_dom`=1) that holds for FILT_CYC consecutive cycles drives `wake_n` to 0. The output falls FILT_CYC+2 clock edges after the input changes: two edges go to the synchroniser and FILT_CYC to the filter.
- R3: A dominant pulse shorter than FILT_CYC cycles leaves `wake_n` at 1.
- R4: The output does not latch. Once recessive (`bus_dom`=0) has held for FILT_CYC cycles, `wake_n` returns to 1 with the same FILT_CYC+2 edge latency. A recessive gap shorter than FILT_CYC cycles leaves the request asserted.
- R5: If the dominant level persists for TMO_CYC consecutive synchronised samples, `wake_n` is forced to 1, TMO_CYC+2 edges after the dominant level began.
- R6: After a timeout, `wake_n` stays at 1 while the bus stays dominant, even through recessive gaps shorter than FILT_CYC. Once recessive has held for FILT_CYC cycles, a new dominant period raises the request again.
- R7: Any recessive sample restarts the dominant timer. Even a single-cycle recessive gap, which the filter rejects, moves the timeout to TMO_CYC+2 edges after dominance resumed.
- R8: While `stby_en` is 0, both counters are held at zero and `wake_n` is 1 from the next edge on. A partially filtered level does not carry across a disable. After re-enable, a dominant bus needs FILT_CYC fresh samples.
- R9: `mode_normal` equals the inverse of `stby_en` delayed by one edge. It never rises because a wake request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_en | input | 1 | 1 selects standby monitoring, 0 selects normal mode |
| bus_dom | input | 1 | Digitised bus level, 1 = dominant, 0 = recessive (asynchronous) |
| wake_n | output | 1 | 0 = wake request detected, 1 = no request |
| mode_normal | output | 1 | Registered mode indication, 1 = normal mode |

## Verification
The hardest state to reach from the ports is the released state after a timeout, and it matters most when the bus briefly goes recessive while the release is in force. The stimulus holds the bus dominant beyond the timeout, then inserts a recessive gap shorter than the filter, and confirms that the request does not reappear. It then applies a full-length recessive period followed by fresh dominance to show that the block re-arms. A second sequence places a single-cycle recessive gap midway through a dominant period. It checks that the output is still low past the original deadline and goes high exactly at the restarted one.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

    typedef enum logic {
        LVL_REC = 1'b0,
        LVL_DOM = 1'b1
    } bus_lvl_e;

    typedef struct packed {
        bus_lvl_e held;      // filtered bus level
        logic     released;  // dominant timeout has withdrawn the request
    } mon_view_t;

    // bits needed for a counter running 0 .. limit-1
    function automatic int ctr_bits(input int limit);
        return (limit < 3) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/persist_filt.sv
module persist_filt
    import stby_wake_pkg::*;
#(
    parameter int HOLD = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  bus_lvl_e lvl_in,
    output bus_lvl_e lvl_out
);
    localparam int             CW   = ctr_bits(HOLD);
    localparam logic [CW-1:0]  LAST = CW'(HOLD - 1);

    logic [CW-1:0] run;
    bus_lvl_e      held;

    // two-way persistence: a differing level must repeat HOLD times in a row
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run  <= '0;
            held <= LVL_REC;
        end else if (lvl_in == held) begin
            run <= '0;
        end else if (run == LAST) begin
            held <= lvl_in;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    assign lvl_out = held;

    // R8: disabled monitoring leaves the filter idle
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> held == LVL_REC);

    // R4: any flip of the filtered level follows the sampled input
    a_r4_flip_follows_input: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && held != $past(held)) |-> held == $past(lvl_in));

    // R3: a flip needs a full run of differing samples
    a_r3_flip_needs_full_run: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && held != $past(held)) |-> $past(run) == LAST);
endmodule

// File: rtl/dom_timeout.sv
module dom_timeout
    import stby_wake_pkg::*;
#(
    parameter int LIMIT = 16000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  bus_lvl_e lvl_in,
    input  bus_lvl_e filt_lvl,
    output logic     released
);
    localparam int             CW   = ctr_bits(LIMIT);
    localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

    logic [CW-1:0] tick;
    logic          rel_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tick  <= '0;
            rel_q <= 1'b0;
        end else begin
            if (lvl_in == LVL_REC) begin
                tick <= '0;
            end else if (!rel_q) begin
                if (tick == LAST) tick <= '0;
                else              tick <= tick + 1'b1;
            end

            if (rel_q) begin
                if (filt_lvl == LVL_REC) rel_q <= 1'b0;
            end else if (lvl_in == LVL_DOM && tick == LAST) begin
                rel_q <= 1'b1;
            end
        end
    end

    assign released = rel_q;

    // R5: release only after a full run of dominant samples
    a_r5_release_after_run: assert property (@(posedge clk) disable iff (rst)
        $rose(rel_q) |-> ($past(lvl_in) == LVL_DOM && $past(tick) == LAST));

    // R6: release ends only once the filtered bus is recessive (or on disable)
    a_r6_hold_until_recessive: assert property (@(posedge clk) disable iff (rst)
        ($fell(rel_q) && $past(en)) |-> $past(filt_lvl) == LVL_REC);

    // R7: a recessive sample leaves the timer at zero
    a_r7_restart_on_recessive: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(lvl_in) == LVL_REC) |-> tick == '0);
endmodule

// File: rtl/stby_wake_mon.sv
module stby_wake_mon
    import stby_wake_pkg::*;
#(
    parameter int FILT_CYC    = 12,
    parameter int TMO_CYC     = 16000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stby_en,
    input  logic bus_dom,
    output logic wake_n,
    output logic mode_normal
);
    logic      sync_q;
    bus_lvl_e  bus_s;
    bus_lvl_e  filt_lvl;
    logic      released;
    mon_view_t view;
    logic      mode_q;

    bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_dom),
        .q   (sync_q)
    );

    assign bus_s = bus_lvl_e'(sync_q);

    persist_filt #(.HOLD(FILT_CYC)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .en      (stby_en),
        .lvl_in  (bus_s),
        .lvl_out (filt_lvl)
    );

    dom_timeout #(.LIMIT(TMO_CYC)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .en       (stby_en),
        .lvl_in   (bus_s),
        .filt_lvl (filt_lvl),
        .released (released)
    );

    always_comb begin
        view.held     = filt_lvl;
        view.released = released;
    end

    assign wake_n = !(view.held == LVL_DOM && !view.released);

    // mode follows the select input only
    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= !stby_en;
    end

    assign mode_normal = mode_q;

    // R9: a pending request never switches the mode
    a_r9_request_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (stby_en && !wake_n) |=> !mode_normal);

    // R8: a request exists only while standby was selected
    a_r8_no_request_when_off: assert property (@(posedge clk) disable iff (rst)
        !wake_n |-> $past(stby_en));

    // R2: a new request is raised only by a dominant sample
    a_r2_request_from_dominant: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_n) |-> $past(bus_s) == LVL_DOM);
endmodule

// File: tb/stby_wake_mon_tb.sv
module stby_wake_mon_tb;
    localparam int F = 4;
    localparam int T = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stby_en = 1'b1;
    logic bus_dom = 1'b0;
    logic wake_n;
    logic mode_normal;

    stby_wake_mon #(.FILT_CYC(F), .TMO_CYC(T), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .stby_en     (stby_en),
        .bus_dom     (bus_dom),
        .wake_n      (wake_n),
        .mode_normal (mode_normal)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int    at;
        bit    is_mode;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push_w(input int d, input logic v, input string tag);
        exp_t e;
        e.at = cyc + d; e.is_mode = 1'b0; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic push_m(input int d, input logic v, input string tag);
        exp_t e;
        e.at = cyc + d; e.is_mode = 1'b1; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare due scoreboard items away from the active edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                check(sb[i].tag, sb[i].is_mode ? mode_normal : wake_n, sb[i].val);
                sb.delete(i);
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R1 wake_n in reset", wake_n, 1'b1);
        check("R1 mode in reset", mode_normal, 1'b0);
        rst = 1'b0;
        idle(4);
        check("R1 wake_n after reset", wake_n, 1'b1);
        check("R1 mode after reset", mode_normal, 1'b0);

        // R2: dominant held
        bus_dom = 1'b1;
        push_w(F + 1, 1'b1, "R2 no request before latency");
        push_w(F + 2, 1'b0, "R2 request after latency");
        idle(F + 6);

        // R4: recessive held releases
        bus_dom = 1'b0;
        push_w(F + 1, 1'b0, "R4 still requesting before latency");
        push_w(F + 2, 1'b1, "R4 non-latching release");
        idle(F + 6);

        // R3: short dominant pulse
        bus_dom = 1'b1;
        for (int d = 1; d <= F + 8; d++) push_w(d, 1'b1, "R3 short pulse ignored");
        idle(F - 1);
        bus_dom = 1'b0;
        idle(F + 10);

        // R2/R3 boundary: pulse of exactly F cycles passes
        bus_dom = 1'b1;
        push_w(F + 1, 1'b1, "R3 exact pulse not yet passed");
        push_w(F + 2, 1'b0, "R2 exact-length pulse passes");
        idle(F);
        bus_dom = 1'b0;
        push_w(F + 1, 1'b0, "R4 request held through filter");
        push_w(F + 2, 1'b1, "R4 release after exact pulse");
        idle(F + 6);

        // R4: short recessive gap during a request
        bus_dom = 1'b1;
        idle(F + 4);
        bus_dom = 1'b0;
        for (int d = 1; d <= F + 8; d++) push_w(d, 1'b0, "R4 short recessive gap ignored");
        idle(F - 1);
        bus_dom = 1'b1;
        idle(F + 10);
        bus_dom = 1'b0;
        push_w(F + 2, 1'b1, "R4 release after gap test");
        idle(F + 6);

        // R5/R6: clamped dominant bus
        bus_dom = 1'b1;
        push_w(F + 2, 1'b0, "R5 request before timeout");
        push_w(T + 1, 1'b0, "R5 still requesting before timeout");
        push_w(T + 2, 1'b1, "R5 timeout releases request");
        push_w(T + 13, 1'b1, "R6 stays released while clamped");
        idle(T + 20);
        bus_dom = 1'b0;
        for (int d = 1; d <= F + 10; d++) push_w(d, 1'b1, "R6 short gap keeps release");
        idle(2);
        bus_dom = 1'b1;
        idle(F + 12);
        bus_dom = 1'b0;
        push_w(F + 2, 1'b1, "R6 idle after recessive");
        idle(F + 6);
        bus_dom = 1'b1;
        push_w(F + 2, 1'b0, "R6 re-armed request");
        idle(F + 4);
        bus_dom = 1'b0;
        idle(F + 6);

        // R7: one-cycle recessive gap restarts the timer
        bus_dom = 1'b1;
        push_w(F + 2, 1'b0, "R7 request raised");
        push_w(T + 4, 1'b0, "R7 original deadline passed");
        push_w(T + 22, 1'b0, "R7 restarted timer still running");
        push_w(T + 23, 1'b1, "R7 restarted timeout releases");
        idle(20);
        bus_dom = 1'b0;
        idle(1);
        bus_dom = 1'b1;
        idle(T + 10);
        bus_dom = 1'b0;
        idle(F + 8);

        // R8/R9: disable in the middle of filtering
        bus_dom = 1'b1;
        idle(F - 1);
        stby_en = 1'b0;
        push_m(1, 1'b1, "R9 normal one edge after select");
        for (int d = 1; d <= F + 6; d++) push_w(d, 1'b1, "R8 standby off keeps idle");
        idle(8);
        stby_en = 1'b1;
        push_m(1, 1'b0, "R9 back to standby");
        push_w(F - 1, 1'b1, "R8 counter restarted from zero");
        push_w(F, 1'b0, "R8 fresh filter after re-enable");
        push_m(F + 2, 1'b0, "R9 request leaves mode unchanged");
        idle(F + 4);

        // R8: disable while requesting
        stby_en = 1'b0;
        push_w(1, 1'b1, "R8 disable drops request");
        push_m(1, 1'b1, "R9 normal after disable");
        idle(4);
        stby_en = 1'b1;
        bus_dom = 1'b0;
        idle(F + 8);

        idle(4);
        if (sb.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule